// File: doc/BRIEF.md
# SPI Hold Pause Gate

This block sits between the SPI pins of a serial slave and the slave's serial engine. It lets the host stop a transfer partway through and restart it later from the same bit, without sending anything again. The chip-select, serial-clock and hold pins are brought into the system clock domain through a synchronizer, and clock edges are found there. While a pause is in force the block drops the serial-clock edge strobes it passes to the engine, raises a freeze output that keeps the engine's state unchanged, and turns off the serial output driver.

The serial-clock level decides when a pause starts and when it ends. If hold is asserted while the serial clock is low, the pause starts at once. If hold is asserted while the clock is high, the pause is deferred until the next falling clock edge. A deferred pause is dropped if hold is released before that edge arrives. A pause ends only when hold is released while the serial clock is low. A release seen while the clock is high has no effect, and the host must pulse hold again. Deselection stays with the engine. This block only clears its own hold state and ignores the hold pin while chip select is high.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset the block is running and not paused: `freeze_o` is 0, no edge strobes are output, and `cs_n_o` is 1.
- R2: A hold assertion (`hold_n_i` low while `cs_n_i` is low) that the synchronizer sees while the synchronized serial clock is low sets `freeze_o` on the next system clock.
- R3: A hold assertion seen while the synchronized serial clock is high does not pause. The pause starts at the next synchronized falling clock edge, and that falling edge is not passed to the engine.
- R4: A deferred hold is cancelled if hold is released before the falling edge arrives. That falling edge is then passed on and no pause follows.
- R5: While `freeze_o` is 1, `sck_rise_o` and `sck_fall_o` stay 0, so serial-clock and data activity has no effect on the engine.
- R6: `so_oe_o` is 0 while paused. At all other times it equals `eng_so_oe_i`.
- R7: A pause ends only when hold is released while the synchronized serial clock is low. A release while the clock is high leaves `freeze_o` at 1, even after the clock goes low again.
- R8: While chip select is high, the hold pin is treated as inactive. Chip select going high clears both a pause and a deferred hold.
- R9: Outside a pause, every synchronized serial-clock edge produces exactly one strobe of the matching polarity, so the engine resumes at the bit where it stopped.
- R10: `cs_n_o` is `cs_n_i` delayed by the SYNC_STAGES synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Chip select pin, active low |
| hold_n_i | input | 1 | Hold pin, active low |
| eng_so_oe_i | input | 1 | The engine's request to drive the serial output |
| sck_rise_o | output | 1 | One-cycle strobe for a serial-clock rising edge, passed to the engine |
| sck_fall_o | output | 1 | One-cycle strobe for a serial-clock falling edge, passed to the engine |
| cs_n_o | output | 1 | Synchronized chip select for the engine |
| freeze_o | output | 1 | Pause in force; the engine holds its state |
| so_oe_o | output | 1 | Output enable for the serial output pad |

## Verification
The embedded assertions check on every cycle that a pause blocks all edge strobes and the output enable. They also check that a pause survives the clock being high, that chip select clears it, and that a pause starts or is cancelled on the cycle after its qualifying condition. The cycle-accurate reference model in the bench covers things no single property covers: the deferred pause taking effect on the later falling edge, and a release at the wrong clock level that leaves the engine paused until hold is pulsed again. It also counts the strobes that get through, which shows the transfer resumes at the same bit.

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic hold_n_i,
  input  logic eng_so_oe_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_n_o,
  output logic freeze_o,
  output logic so_oe_o
);

  localparam int TOP = SYNC_STAGES - 1;

  typedef enum logic [1:0] {RUN, PEND, PAUSE} gate_t;

  logic [TOP:0] sck_q, cs_q, hold_q;
  logic         sck_d, heff_d;
  gate_t        st, st_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      hold_q <= '1;
    end else begin
      sck_q  <= {sck_q[TOP-1:0], sck_i};
      cs_q   <= {cs_q[TOP-1:0], cs_n_i};
      hold_q <= {hold_q[TOP-1:0], hold_n_i};
    end

  wire s_sck  = sck_q[TOP];
  wire s_cs_n = cs_q[TOP];
  wire heff   = ~hold_q[TOP] & ~s_cs_n;
  wire rise   = s_sck & ~sck_d;
  wire fall   = ~s_sck & sck_d;
  wire h_on   = heff & ~heff_d;
  wire h_off  = ~heff & heff_d;

  always_comb begin
    st_nx = st;
    if (s_cs_n) st_nx = RUN;
    else case (st)
      RUN:     if (h_on) st_nx = s_sck ? PEND : PAUSE;
      PEND:    if (!heff) st_nx = RUN;
               else if (fall) st_nx = PAUSE;
      PAUSE:   if (h_off && !s_sck) st_nx = RUN;
      default: st_nx = RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= RUN;
      sck_d  <= 1'b0;
      heff_d <= 1'b0;
    end else begin
      st     <= st_nx;
      sck_d  <= s_sck;
      heff_d <= heff;
    end

  assign freeze_o   = (st == PAUSE);
  assign cs_n_o     = s_cs_n;
  assign sck_rise_o = rise & ~freeze_o;
  assign sck_fall_o = fall & ((st == RUN) | ((st == PEND) & ~heff));
  assign so_oe_o    = eng_so_oe_i & ~freeze_o;

  a_r5_no_edges_paused: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> (!sck_rise_o && !sck_fall_o));

  a_r6_so_off_paused: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> !so_oe_o);

  a_r8_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |=> !freeze_o);

  a_r7_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_o && s_sck && !cs_n_o) |=> freeze_o);

  a_r2_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && h_on && !s_sck && !cs_n_o) |=> freeze_o);

  a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PEND && !heff) |=> !freeze_o);

endmodule

// File: tb/spi_hold_gate_tb.sv
module spi_hold_gate_tb;
  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, hold_n = 1, eoe = 0;
  logic rise_o, fall_o, csn_o, frz_o, oe_o;
  int vec = 0, bad = 0, nrise = 0, nfall = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_hold_gate #(.SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .eng_so_oe_i(eoe), .sck_rise_o(rise_o), .sck_fall_o(fall_o),
    .cs_n_o(csn_o), .freeze_o(frz_o), .so_oe_o(oe_o));

  bit qs[$] = '{0, 0};
  bit qc[$] = '{1, 1};
  bit qh[$] = '{1, 1};
  bit m_sck_d = 0, m_heff_d = 0;
  int m_st = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      qs = '{0, 0}; qc = '{1, 1}; qh = '{1, 1};
      m_sck_d = 0; m_heff_d = 0; m_st = 0;
    end else begin
      bit ssck, scs, heff, fl;
      ssck = qs[0]; scs = qc[0];
      heff = !qh[0] && !scs;
      fl = !ssck && m_sck_d;
      if (scs) m_st = 0;
      else if (m_st == 0) begin
        if (heff && !m_heff_d) m_st = ssck ? 1 : 2;
      end else if (m_st == 1) begin
        if (!heff) m_st = 0;
        else if (fl) m_st = 2;
      end else begin
        if (!heff && m_heff_d && !ssck) m_st = 0;
      end
      m_sck_d = ssck; m_heff_d = heff;
      qs.push_back(sck);    void'(qs.pop_front());
      qc.push_back(cs_n);   void'(qc.pop_front());
      qh.push_back(hold_n); void'(qh.pop_front());
    end
  end

  task automatic cmp(string tag, logic act, logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit ssck, heff, er, ef;
    ssck = qs[0];
    heff = !qh[0] && !qc[0];
    er = ssck && !m_sck_d && m_st != 2;
    ef = !ssck && m_sck_d && (m_st == 0 || (m_st == 1 && !heff));
    cmp("R5 sck_rise_o", rise_o, er);
    cmp("R3 sck_fall_o", fall_o, ef);
    cmp("R2 freeze_o", frz_o, m_st == 2);
    cmp("R6 so_oe_o", oe_o, eoe && m_st != 2);
    cmp("R10 cs_n_o", csn_o, qc[0]);
    if (rise_o) nrise++;
    if (fall_o) nfall++;
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse();
    sck = 1; wt(4);
    sck = 0; wt(4);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog: actual timeout expected finish");
    bad++; vec++;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    int r0, f0;
    wt(3); rst_n = 1; wt(2);
    cmp("R1 reset freeze", frz_o, 0);
    cmp("R1 reset cs_n", csn_o, 1);
    cmp("R1 reset oe", oe_o, 0);

    cs_n = 0; eoe = 1; wt(4);
    cmp("R10 cs low synced", csn_o, 0);
    r0 = nrise;
    repeat (3) pulse();
    cmp("R9 three rises forwarded", nrise == r0 + 3, 1);

    hold_n = 0; wt(4);
    cmp("R2 immediate pause", frz_o, 1);
    cmp("R6 so off while paused", oe_o, 0);
    r0 = nrise;
    repeat (2) pulse();
    cmp("R5 no rises while paused", nrise == r0, 1);
    hold_n = 1; wt(4);
    cmp("R7 resume on low-clock release", frz_o, 0);
    repeat (2) pulse();
    cmp("R9 rises resume one-for-one", nrise == r0 + 2, 1);

    sck = 1; hold_n = 0; wt(4);
    cmp("R3 no pause while clock high", frz_o, 0);
    f0 = nfall;
    sck = 0; wt(4);
    cmp("R3 pause at falling edge", frz_o, 1);
    cmp("R3 entry fall not forwarded", nfall == f0, 1);
    sck = 1; wt(4);
    hold_n = 1; wt(4);
    cmp("R7 high-clock release ignored", frz_o, 1);
    sck = 0; wt(4);
    cmp("R7 still paused after clock low", frz_o, 1);
    hold_n = 0; wt(4);
    hold_n = 1; wt(4);
    cmp("R7 resume after fresh release", frz_o, 0);

    sck = 1; wt(4);
    hold_n = 0; wt(4);
    hold_n = 1; wt(4);
    f0 = nfall;
    sck = 0; wt(4);
    cmp("R4 cancelled deferred hold", frz_o, 0);
    cmp("R4 fall forwarded", nfall == f0 + 1, 1);

    hold_n = 0; wt(4);
    cmp("R8 paused before deselect", frz_o, 1);
    cs_n = 1; wt(4);
    cmp("R8 deselect clears pause", frz_o, 0);
    hold_n = 1; wt(4);
    hold_n = 0; wt(4);
    cmp("R8 hold ignored while deselected", frz_o, 0);
    hold_n = 1; wt(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule